// File: doc/BRIEF.md
# Lockstep Serial Converter Capture Array

This block reads a bank of identical successive-approximation converters that share one serial clock and one active-low select line while each returns its result on a private data line. A single-cycle start request opens one frame on every lane at once. The frame gives the converters their sampling clocks, skips one leading zero bit, and then shifts in a 10-bit result, most significant bit first, on each rising serial clock edge. Each lane keeps only the top eight bits of its result. All lanes publish their bytes together, marked by a one-cycle valid strobe.

The serial clock comes from dividing the system clock. Its high and low phases each last `HALF_DIV` system cycles, so a 50 MHz system clock with `HALF_DIV` = 9 gives about 2.8 MHz. With that setting and 13 edges per frame plus the idle gap, the frame rate stays below 200 k conversions per second. A frame is driven by a six-state machine:
- `ST_IDLE`: select high, clock parked low. A start request takes the transition to `ST_SAMPLE`.
- `ST_SAMPLE`: select low and the clock running. After `SAMPLE_CLKS` rising edges it moves to `ST_NULL`.
- `ST_NULL`: one more rising edge, which carries the zero bit, leads to `ST_DATA`.
- `ST_DATA`: `RES_BITS` rising edges, each shifting one bit into every lane. The last of them leads to `ST_TAIL`.
- `ST_TAIL`: lasts until the next falling edge of the clock. That edge latches all lanes, pulses valid and moves to `ST_GAP`.
- `ST_GAP`: select high for one full serial clock period, then back to `ST_IDLE`.

Top module: `adc_capture_array`

## Requirements
- R1: During reset and immediately after it, cs_n is 1, sclk is 0, busy is 0, valid is 0 and data_out is all zeros.
- R2: A start pulse seen while the block is idle drives cs_n low and busy high in the very next system cycle.
- R3: While cs_n is low, every high phase and every low phase of sclk lasts exactly HALF_DIV system cycles. While cs_n is high, sclk stays low.
- R4: Each frame contains exactly SAMPLE_CLKS + 1 + RES_BITS rising sclk edges, which is 13 with the default parameters.
- R5: Lane bits present at rising edges 1 to SAMPLE_CLKS+1 are discarded. The bits at the following RES_BITS rising edges form the result, with the first of them as the most significant bit.
- R6: Lane i reports bits [9:2] of its 10-bit result on data_out[8*i+7 : 8*i].
- R7: All lanes are captured in the same frame, each from its own sdata bit and independently of the others.
- R8: cs_n returns high on the first sclk falling edge after the last data edge. It then stays high for at least 2*HALF_DIV+1 system cycles, and exactly that many when start is held high.
- R9: valid is high for exactly one cycle per frame, and busy is still high in that cycle. data_out changes only on that cycle and otherwise holds its value.
- R10: A start request while busy is high is ignored: it neither adds a frame nor disturbs the frame in progress.
- R11: A start present in the first cycle in which busy is low again is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion frame |
| sdata | input | LANES | Serial result bit from each converter |
| sclk | output | 1 | Shared serial clock, idles low |
| cs_n | output | 1 | Shared active-low converter select |
| busy | output | 1 | A frame or the following idle gap is in progress |
| valid | output | 1 | One-cycle strobe: all lane bytes updated |
| data_out | output | LANES*OUT_BITS | Lane bytes, lane i at bits [8i+7:8i] |

## Verification
The one-cycle valid strobe and a new start request can land in the same cycle. The bench provokes this by raising start on the valid cycle and holding it there. It then judges the result by counting how long cs_n stays high: with a correct design that is exactly 2*HALF_DIV+1 cycles, because the request is refused during the gap and accepted in the first idle cycle. A second collision puts a start pulse in the middle of the data shift. It is judged by counting cs_n falling edges and by checking that every lane byte still equals the upper eight bits of that lane's expected value.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_NULL   = 3'd2,
        ST_DATA   = 3'd3,
        ST_TAIL   = 3'd4,
        ST_GAP    = 3'd5
    } cap_state_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int unsigned HALF_DIV = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int unsigned CW = adc_cap_pkg::cnt_width(HALF_DIV);

    logic [CW-1:0] div_cnt;
    logic          expire;

    assign expire    = (div_cnt == CW'(HALF_DIV - 1));
    assign rise_tick = run && expire && !sclk;
    assign fall_tick = run && expire && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
        end else if (!run) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
        end else if (expire) begin
            div_cnt <= '0;
            sclk    <= ~sclk;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R3
    sclk_parks_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);

    // R3
    sclk_edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> sclk);

endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm #(
    parameter int unsigned SAMPLE_CLKS = 2,
    parameter int unsigned RES_BITS    = 10,
    parameter int unsigned GAP_CYCLES  = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rise_tick,
    input  logic fall_tick,
    output logic run,
    output logic cs_n,
    output logic busy,
    output logic shift_en,
    output logic latch
);
    import adc_cap_pkg::*;

    localparam int unsigned RMAX = (SAMPLE_CLKS > RES_BITS) ? SAMPLE_CLKS : RES_BITS;
    localparam int unsigned RCW  = cnt_width(RMAX);
    localparam int unsigned GCW  = cnt_width(GAP_CYCLES);

    cap_state_t     state_q, state_d;
    logic [RCW-1:0] edge_cnt;
    logic [GCW-1:0] gap_cnt;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SAMPLE;
            ST_SAMPLE: if (rise_tick && edge_cnt == RCW'(SAMPLE_CLKS - 1)) state_d = ST_NULL;
            ST_NULL:   if (rise_tick) state_d = ST_DATA;
            ST_DATA:   if (rise_tick && edge_cnt == RCW'(RES_BITS - 1)) state_d = ST_TAIL;
            ST_TAIL:   if (fall_tick) state_d = ST_GAP;
            ST_GAP:    if (gap_cnt == GCW'(GAP_CYCLES - 1)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // per-state counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            gap_cnt  <= '0;
        end else begin
            if (state_d != state_q) begin
                edge_cnt <= '0;
            end else if (rise_tick) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
            if (state_q == ST_GAP) begin
                gap_cnt <= gap_cnt + 1'b1;
            end else begin
                gap_cnt <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        run      = 1'b0;
        busy     = 1'b1;
        shift_en = 1'b0;
        latch    = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_SAMPLE: run = 1'b1;
            ST_NULL:   run = 1'b1;
            ST_DATA: begin
                run      = 1'b1;
                shift_en = rise_tick;
            end
            ST_TAIL: begin
                run   = 1'b1;
                latch = fall_tick;
            end
            ST_GAP:    run = 1'b0;
            default:   busy = 1'b0;
        endcase
        cs_n = !run;
    end

    // R2
    start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> state_q == ST_SAMPLE);

    // R10
    gap_refuses_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |=> (state_q == ST_GAP || state_q == ST_IDLE));

    // R10
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_GAP) |=> state_q != ST_IDLE);

endmodule

// File: rtl/adc_lane_shift.sv
module adc_lane_shift #(
    parameter int unsigned RES_BITS = 10,
    parameter int unsigned OUT_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                latch,
    input  logic                sdi,
    output logic [OUT_BITS-1:0] byte_q
);
    logic [RES_BITS-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            byte_q <= '0;
        end else begin
            if (shift_en) begin
                shreg <= {shreg[RES_BITS-2:0], sdi};
            end
            if (latch) begin
                byte_q <= shreg[RES_BITS-1 -: OUT_BITS];
            end
        end
    end

    // R9
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(byte_q));

endmodule

// File: rtl/adc_capture_array.sv
module adc_capture_array #(
    parameter int unsigned LANES       = 16,
    parameter int unsigned RES_BITS    = 10,
    parameter int unsigned OUT_BITS    = 8,
    parameter int unsigned SAMPLE_CLKS = 2,
    parameter int unsigned HALF_DIV    = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LANES-1:0]          sdata,
    output logic                      sclk,
    output logic                      cs_n,
    output logic                      busy,
    output logic                      valid,
    output logic [LANES*OUT_BITS-1:0] data_out
);
    localparam int unsigned GAP_CYCLES  = 2 * HALF_DIV;
    localparam int unsigned FRAME_EDGES = SAMPLE_CLKS + 1 + RES_BITS;

    logic run, rise_tick, fall_tick, shift_en, latch;

    adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    adc_frame_fsm #(
        .SAMPLE_CLKS (SAMPLE_CLKS),
        .RES_BITS    (RES_BITS),
        .GAP_CYCLES  (GAP_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .run       (run),
        .cs_n      (cs_n),
        .busy      (busy),
        .shift_en  (shift_en),
        .latch     (latch)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        adc_lane_shift #(.RES_BITS(RES_BITS), .OUT_BITS(OUT_BITS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .latch    (latch),
            .sdi      (sdata[g]),
            .byte_q   (data_out[g*OUT_BITS +: OUT_BITS])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= latch;
        end
    end

    // ---------------- checks on the assembled block ----------------
    logic [15:0] hi_len, cs_hi_len;
    logic [7:0]  frame_edges;
    logic        framed_once;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len      <= '0;
            cs_hi_len   <= '0;
            frame_edges <= '0;
            framed_once <= 1'b0;
        end else begin
            hi_len <= sclk ? ((hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1) : '0;
            cs_hi_len <= cs_n ? ((cs_hi_len == 16'hFFFF) ? cs_hi_len : cs_hi_len + 1'b1) : '0;
            if (cs_n) begin
                frame_edges <= '0;
            end else if (rise_tick) begin
                frame_edges <= frame_edges + 1'b1;
            end
            if (!cs_n) framed_once <= 1'b1;
        end
    end

    // R3
    sclk_high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> hi_len == 16'(HALF_DIV));

    // R3
    sclk_quiet_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4
    frame_edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> frame_edges == 8'(FRAME_EDGES));

    // R8
    select_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && framed_once) |-> cs_hi_len >= 16'(GAP_CYCLES + 1));

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R9
    valid_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> busy);

endmodule

// File: tb/adc_capture_array_test.sv
module adc_capture_array_test;
    localparam int LN = 16;
    localparam int RB = 10;
    localparam int OB = 8;
    localparam int SC = 2;
    localparam int H  = 2;
    localparam int EDGES = SC + 1 + RB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LN-1:0]     sdata = '1;
    logic              sclk, cs_n, busy, valid;
    logic [LN*OB-1:0]  data_out;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    adc_capture_array #(
        .LANES(LN), .RES_BITS(RB), .OUT_BITS(OB), .SAMPLE_CLKS(SC), .HALF_DIV(H)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sdata(sdata),
        .sclk(sclk), .cs_n(cs_n), .busy(busy), .valid(valid), .data_out(data_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter model: drives each lane after falling sclk edges
    logic [RB-1:0] vals [LN];
    int rc = 0;
    int frames = 0;
    bit monitors_on = 1'b0;

    always @(negedge cs_n) begin
        rc = 0;
        frames++;
        sdata = '1;
    end
    always @(posedge sclk) if (!cs_n) rc++;
    always @(negedge sclk) begin
        if (!cs_n) begin
            if (rc == SC) sdata = '1;       // leading zero slot: drive ones, must be discarded (R5)
            else if (rc > SC && rc < EDGES) begin
                for (int i = 0; i < LN; i++) sdata[i] = vals[i][RB-1-(rc-SC-1)];
            end else sdata = '1;
        end
    end
    always @(posedge cs_n) if (monitors_on) chk(rc == EDGES, "R4 rising edges per frame", rc, EDGES);

    // serial clock phase monitor (R3)
    int hl = 0, ll = 0;
    always @(negedge clk) begin
        if (monitors_on) begin
            if (sclk) begin
                if (ll != 0) begin
                    chk(ll == H, "R3 low phase length", ll, H);
                    ll = 0;
                end
                hl++;
            end else begin
                if (hl != 0) begin
                    chk(hl == H, "R3 high phase length", hl, H);
                    hl = 0;
                end
                if (!cs_n) ll++;
                else ll = 0;
                if (cs_n && sclk) chk(0, "R3 sclk low while deselected", 1, 0);
            end
        end
    end

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk);
            if (valid) begin ok = 1'b1; return; end
        end
        chk(0, "R9 valid never arrived", 0, 1);
    endtask

    task automatic check_bytes(input string req);
        for (int i = 0; i < LN; i++)
            chk(data_out[i*OB +: OB] == OB'(vals[i] >> (RB-OB)), req,
                data_out[i*OB +: OB], vals[i] >> (RB-OB));
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    initial begin
        #3_800_000;
        chk(0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        bit ok;
        int n0, len;
        logic [LN*OB-1:0] snap;
        for (int i = 0; i < LN; i++) vals[i] = '0;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        chk(busy == 1'b0 && valid == 1'b0, "R1 busy/valid in reset", {busy, valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(data_out == '0, "R1 data_out after reset", data_out[31:0], 0);
        chk(cs_n == 1'b1 && busy == 1'b0, "R1 idle after reset", {cs_n, busy}, 2);
        monitors_on = 1'b1;

        // R2 start to select latency, R5/R6/R7 first frame
        for (int i = 0; i < LN; i++) vals[i] = RB'(i * 61 + 7);
        pulse_start();
        chk(cs_n == 1'b0, "R2 cs_n low after start", cs_n, 0);
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        wait_valid(ok);
        chk(busy == 1'b1, "R9 busy during valid", busy, 1);
        check_bytes("R6 R7 lane byte");
        @(negedge clk);
        chk(valid == 1'b0, "R9 valid one cycle", valid, 0);

        // R9 hold: change converter values, no frame, outputs must not move
        snap = data_out;
        for (int i = 0; i < LN; i++) vals[i] = ~vals[i];
        repeat (40) @(negedge clk);
        chk(data_out == snap, "R9 data_out held", data_out[31:0], snap[31:0]);

        // sweep: every lane walks all 1024 values (R5, R6, R7)
        for (int f = 0; f < (1 << RB); f++) begin
            for (int i = 0; i < LN; i++) vals[i] = RB'(f + i * 67);
            pulse_start();
            wait_valid(ok);
            check_bytes("R5 R6 R7 sweep byte");
            while (busy) @(negedge clk);
        end

        // R10 start in the middle of the data shift
        for (int i = 0; i < LN; i++) vals[i] = (i % 2 == 0) ? RB'(10'h2AA) : RB'(10'h155);
        n0 = frames;
        pulse_start();
        repeat (8 * H + 3) @(negedge clk);
        chk(busy == 1'b1 && cs_n == 1'b0, "R10 mid frame state", {busy, cs_n}, 2);
        pulse_start();
        wait_valid(ok);
        check_bytes("R10 bytes unaffected by extra start");
        repeat (6 * H + 4) @(negedge clk);
        chk(frames == n0 + 1, "R10 single frame", frames - n0, 1);
        chk(busy == 1'b0, "R10 back to idle", busy, 0);

        // R8 R11 collision: start raised on the valid cycle and held
        for (int i = 0; i < LN; i++) vals[i] = RB'(1 << (i % RB));
        pulse_start();
        wait_valid(ok);
        start = 1'b1;
        len = 0;
        while (cs_n && len < 1000) begin
            len++;
            if (cs_n && !busy) chk(start, "R11 start present when idle", start, 1);
            @(negedge clk);
        end
        start = 1'b0;
        chk(len == 2 * H + 1, "R8 R11 select high length", len, 2 * H + 1);
        for (int i = 0; i < LN; i++) vals[i] = RB'(1023 - i * 3);
        wait_valid(ok);
        check_bytes("R11 accepted frame bytes");

        // all-ones and all-zeros extremes
        for (int i = 0; i < LN; i++) vals[i] = '1;
        while (busy) @(negedge clk);
        pulse_start();
        wait_valid(ok);
        check_bytes("R6 all ones");
        for (int i = 0; i < LN; i++) vals[i] = '0;
        while (busy) @(negedge clk);
        pulse_start();
        wait_valid(ok);
        check_bytes("R5 all zeros with ones in skipped slots");

        repeat (10) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule